// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Accounting Registers

This block is the interrupt side of one DMA channel's register file. Internal event pulses from the transfer engine set sticky bits in a twelve-bit status register. Software clears these bits by writing ones back. A per-source mask decides which status bits reach the single interrupt line. Software never writes the mask directly. One write address clears mask bits to unmask sources, and a second write address sets mask bits to silence sources. The mask itself can only be read.

Two eight-bit counters track how many descriptors that asked for a completion interrupt have finished, one for the source side and one for the destination side. Reading a counter returns its value and empties it in the same access. A counter never wraps. It stops at its top value, and the increment that cannot be recorded raises that side's accounting-error status bit. Any access to an address that has no register in that direction raises an access-error status bit.

The register port is a plain 32-bit address, write and read interface. Read data is registered and holds its value between reads.

Top module: `dma_irq_regs`

## Requirements
- R1: After a synchronous active-low reset, the status reads 0, the mask reads 0xFFF, both counters read 0, and the interrupt line is low.
- R2: A pulse on event input bit k sets status bit k on the next clock edge, and the bit stays set until software clears it. Bit 10 means transfer done. Bit 9 means write-data bus error. Bit 8 means read-data bus error. Bit 7 means destination-descriptor fetch error. Bit 6 means source-descriptor fetch error. Bit 3 means byte-counter overflow. Bit 2 means destination descriptor done.
- R3: A write to address 0x100 clears every status bit whose write-data bit is 1 and leaves every other status bit unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: Writing ones to address 0x108 clears the matching mask bits, writing ones to address 0x10C sets them, and address 0x104 reads the mask in bits 11:0.
- R6: The interrupt output is a register that holds the OR of (status AND NOT mask) as it stood one clock edge earlier. A mask bit of 1 therefore suppresses that source.
- R7: Each cycle with a pulse on the source or destination increment input adds one to that side's counter. A read of address 0x190 (source) or 0x194 (destination) returns the count and clears it. An increment that arrives in the same cycle as the read leaves the counter at 1.
- R8: A counter holds at 255 when it is already at 255 and another increment arrives without a read in the same cycle. That lost increment sets status bit 4 for the source counter or status bit 5 for the destination counter.
- R9: A write to any address other than 0x100, 0x108 or 0x10C, or a read from any address other than 0x100, 0x104, 0x190 or 0x194, sets status bit 0 and changes no other register.
- R10: Read data appears on the clock edge after the read strobe, holds its value until the next read, and is 0 for an unmapped read. Bits above the register's width are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 32 | Registered read data |
| evt_pulse | input | 12 | One-cycle event pulses, one per status bit |
| src_acct_inc | input | 1 | Source-side completion-interrupt descriptor finished |
| dst_acct_inc | input | 1 | Destination-side completion-interrupt descriptor finished |
| irq | output | 1 | Combined interrupt line |

## Verification
A wrong status or mask bit appears on the interrupt line two edges after the event or register write that caused it. The next read of the status or mask address also shows the error, on the edge after the read strobe. A counter that drops a clear or saturates at the wrong value shows up at the next read of that side, and it often also shows up as a missing or unexpected accounting-error bit in the status. The reference model tracks every register each cycle, so any divergence in the read data or the interrupt line is reported in the cycle it becomes visible.

// File: rtl/dma_irq_pkg.sv
// Shared constants for the DMA interrupt register block.
// Assumes the status vector is at least 11 bits wide, because fixed bit positions are used.
package dma_irq_pkg;
    localparam int unsigned OFS_STATUS   = 'h100;
    localparam int unsigned OFS_MASK     = 'h104;
    localparam int unsigned OFS_UNMASK   = 'h108;
    localparam int unsigned OFS_SILENCE  = 'h10C;
    localparam int unsigned OFS_SRC_ACCT = 'h190;
    localparam int unsigned OFS_DST_ACCT = 'h194;

    localparam int unsigned BIT_BAD_ACCESS   = 0;
    localparam int unsigned BIT_SRC_ACCT_ERR = 4;
    localparam int unsigned BIT_DST_ACCT_ERR = 5;
endpackage

// File: rtl/irq_acct_counter.sv
// Clear-on-read saturating counter of finished completion-interrupt descriptors.
// Assumes bump_i and drain_i are single-cycle strobes. A drain that coincides with a bump restarts the count at 1.
module irq_acct_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    input  logic             drain_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_q;

    // Flags an increment that is lost because the counter is full.
    assign sat_hit_o = bump_i && !drain_i && (count_q == CNT_MAX);
    assign count_o   = count_q;

    // Counts bumps, saturates at full scale, and restarts on a drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (drain_i) begin
            count_q <= bump_i ? CNT_W'(1) : '0;
        end else if (bump_i && (count_q != CNT_MAX)) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !drain_i && count_q == CNT_MAX) |=> (count_q == CNT_MAX));
    // R7
    drain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && !bump_i) |=> (count_q == '0));
    // R7
    drain_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_i && bump_i) |=> (count_q == CNT_W'(1)));
endmodule

// File: rtl/irq_status_mask.sv
// Sticky status bits with write-one-to-clear, and a mask that separate set and clear strobes update.
// Assumes the unmask and silence strobes never occur together, because they come from one address port.
module irq_status_mask #(
    parameter int unsigned NSRC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] clr_bits_i,
    input  logic            unmask_en_i,
    input  logic [NSRC-1:0] unmask_bits_i,
    input  logic            silence_en_i,
    input  logic [NSRC-1:0] silence_bits_i,
    output logic [NSRC-1:0] status_o,
    output logic [NSRC-1:0] mask_o
);
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] clr_eff;

    // Selects the bits a status write clears.
    assign clr_eff = clr_en_i ? clr_bits_i : '0;

    // Updates the status; a set in the same cycle wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | set_i;
    end

    // Updates the mask; it resets with every source suppressed.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '1;
        else if (unmask_en_i)  mask_q <= mask_q & ~unmask_bits_i;
        else if (silence_en_i) mask_q <= mask_q | silence_bits_i;
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
    // R3
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && set_i == '0) |=> ((status_q & $past(clr_bits_i)) == '0));
    // R2
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_en_i && set_i == '0) |=> $stable(status_q));
    // R5
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_en_i |=> ((mask_q & $past(unmask_bits_i)) == '0));
    // R5
    silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (silence_en_i && !unmask_en_i) |=> ((mask_q & $past(silence_bits_i)) == $past(silence_bits_i)));
endmodule

// File: rtl/dma_irq_regs.sv
// Interrupt status, mask and completion accounting registers for one DMA channel.
// Assumes NSRC <= DATA_W, CNT_W <= DATA_W and NSRC > 10. Read data is registered and holds between reads.
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NSRC   = 12,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic [NSRC-1:0]   evt_pulse,
    input  logic              src_acct_inc,
    input  logic              dst_acct_inc,
    output logic              irq
);
    localparam int unsigned NSIDE = 2;

    logic hit_status, hit_mask, hit_unmask, hit_silence;
    logic [NSIDE-1:0] hit_acct;
    logic [NSIDE-1:0] acct_bump;
    logic [NSIDE-1:0] acct_sat;
    logic [CNT_W-1:0] acct_cnt [NSIDE];
    logic wr_ok, rd_ok, bad_access;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] mask;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;
    logic irq_q;
    logic unused_wr_hi;

    // Decodes the register address.
    assign hit_status  = (reg_addr == ADDR_W'(OFS_STATUS));
    assign hit_mask    = (reg_addr == ADDR_W'(OFS_MASK));
    assign hit_unmask  = (reg_addr == ADDR_W'(OFS_UNMASK));
    assign hit_silence = (reg_addr == ADDR_W'(OFS_SILENCE));
    assign hit_acct[0] = (reg_addr == ADDR_W'(OFS_SRC_ACCT));
    assign hit_acct[1] = (reg_addr == ADDR_W'(OFS_DST_ACCT));
    assign acct_bump   = {dst_acct_inc, src_acct_inc};

    // Flags accesses that have no register in their direction.
    assign wr_ok      = hit_status | hit_unmask | hit_silence;
    assign rd_ok      = hit_status | hit_mask | (|hit_acct);
    assign bad_access = (reg_wr_en & ~wr_ok) | (reg_rd_en & ~rd_ok);

    assign unused_wr_hi = ^reg_wr_data[DATA_W-1:NSRC];

    // Builds one accounting counter per side; side 0 is the source side.
    for (genvar side = 0; side < NSIDE; side++) begin : g_acct
        irq_acct_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .bump_i    (acct_bump[side]),
            .drain_i   (reg_rd_en & hit_acct[side]),
            .count_o   (acct_cnt[side]),
            .sat_hit_o (acct_sat[side])
        );
    end

    // Merges external events with internally detected errors.
    always_comb begin
        set_vec = evt_pulse;
        set_vec[BIT_SRC_ACCT_ERR] = set_vec[BIT_SRC_ACCT_ERR] | acct_sat[0];
        set_vec[BIT_DST_ACCT_ERR] = set_vec[BIT_DST_ACCT_ERR] | acct_sat[1];
        set_vec[BIT_BAD_ACCESS]   = set_vec[BIT_BAD_ACCESS] | bad_access;
    end

    irq_status_mask #(.NSRC(NSRC)) u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .set_i          (set_vec),
        .clr_en_i       (reg_wr_en & hit_status),
        .clr_bits_i     (reg_wr_data[NSRC-1:0]),
        .unmask_en_i    (reg_wr_en & hit_unmask),
        .unmask_bits_i  (reg_wr_data[NSRC-1:0]),
        .silence_en_i   (reg_wr_en & hit_silence),
        .silence_bits_i (reg_wr_data[NSRC-1:0]),
        .status_o       (status),
        .mask_o         (mask)
    );

    // Selects the read value; unmapped addresses read as zero.
    always_comb begin
        rd_next = '0;
        if (hit_status)  rd_next = DATA_W'(status);
        if (hit_mask)    rd_next = DATA_W'(mask);
        if (hit_acct[0]) rd_next = DATA_W'(acct_cnt[0]);
        if (hit_acct[1]) rd_next = DATA_W'(acct_cnt[1]);
    end

    // Captures read data on a read strobe and holds it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= '0;
        else if (reg_rd_en) rd_q <= rd_next;
    end

    // Registers the combined interrupt from the unmasked status.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status & ~mask);
    end

    assign reg_rd_data = rd_q;
    assign irq         = irq_q;

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq);
    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~mask) != '0) |=> irq);
    // R9
    bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr != ADDR_W'(OFS_STATUS) && reg_addr != ADDR_W'(OFS_UNMASK)
         && reg_addr != ADDR_W'(OFS_SILENCE)) |=> status[BIT_BAD_ACCESS]);
    // R10
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == '0) |=> (reg_rd_data == '0));
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rd_data));
endmodule

// File: tb/dma_irq_regs_bench.sv
// Bench: a behavioural reference model updated each clock edge; irq and read data are compared every cycle,
// and directed checks carry hand-computed expected values.
module dma_irq_regs_bench;
    localparam int AW = 12;
    localparam int NS = 12;
    localparam logic [AW-1:0] A_ST = 12'h100, A_MK = 12'h104, A_EN = 12'h108,
                              A_DS = 12'h10C, A_SA = 12'h190, A_DA = 12'h194;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [31:0] wd = '0;
    logic [NS-1:0] ev = '0;
    logic sinc = 1'b0, dinc = 1'b0;
    logic [31:0] rdata;
    logic irq;

    always #2 clk = ~clk;

    dma_irq_regs u_dma_irq_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr_en(wr), .reg_wr_data(wd),
        .reg_rd_en(rd), .reg_rd_data(rdata), .evt_pulse(ev),
        .src_acct_inc(sinc), .dst_acct_inc(dinc), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 0;

    // Reference model state.
    logic [NS-1:0] m_st, m_mk;
    int m_sc, m_dc;
    logic m_irq;
    logic [31:0] m_rd;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin : model
        logic [NS-1:0] setv, clr;
        logic wok, rok;
        if (!rst_n) begin
            m_st = '0; m_mk = '1; m_sc = 0; m_dc = 0; m_irq = 1'b0; m_rd = '0;
        end else begin
            wok = (addr == A_ST) || (addr == A_EN) || (addr == A_DS);
            rok = (addr == A_ST) || (addr == A_MK) || (addr == A_SA) || (addr == A_DA);
            setv = ev;
            if (sinc && !(rd && addr == A_SA) && m_sc == 255) setv[4] = 1'b1;
            if (dinc && !(rd && addr == A_DA) && m_dc == 255) setv[5] = 1'b1;
            if ((wr && !wok) || (rd && !rok)) setv[0] = 1'b1;
            m_irq = (m_st & ~m_mk) != '0;
            if (rd) begin
                if (addr == A_ST) m_rd = 32'(m_st);
                else if (addr == A_MK) m_rd = 32'(m_mk);
                else if (addr == A_SA) m_rd = 32'(m_sc);
                else if (addr == A_DA) m_rd = 32'(m_dc);
                else m_rd = '0;
            end
            clr = (wr && addr == A_ST) ? wd[NS-1:0] : '0;
            m_st = (m_st & ~clr) | setv;
            if (wr && addr == A_EN) m_mk = m_mk & ~wd[NS-1:0];
            if (wr && addr == A_DS) m_mk = m_mk | wd[NS-1:0];
            if (rd && addr == A_SA) m_sc = sinc ? 1 : 0;
            else if (sinc && m_sc < 255) m_sc = m_sc + 1;
            if (rd && addr == A_DA) m_dc = dinc ? 1 : 0;
            else if (dinc && m_dc < 255) m_dc = m_dc + 1;
        end
    end

    // Compares the ports against the model in every cycle after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, 32'(irq), 32'(m_irq), "irq vs model");
            chk(tag, rdata, m_rd, "read data vs model");
        end
    end

    task automatic wr_reg(logic [AW-1:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wd = d;
        @(negedge clk);
        wr = 1'b0; wd = '0;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string req);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        chk(req, rdata, exp, $sformatf("read 0x%0h", a));
    endtask

    task automatic pulse(logic [NS-1:0] v);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic bump(bit dst, int n);
        for (int i = 0; i < n; i++) begin
            if (dst) dinc = 1'b1; else sinc = 1'b1;
            @(negedge clk);
        end
        sinc = 1'b0; dinc = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        tag = "R1";
        chk("R1", 32'(irq), 0, "irq after reset");
        rd_chk(A_ST, 32'h000, "R1");
        rd_chk(A_MK, 32'hFFF, "R1");
        rd_chk(A_SA, 0, "R1");
        rd_chk(A_DA, 0, "R1");
        // R2 event sets a sticky bit; masked source keeps irq low
        tag = "R2";
        pulse(12'h400);
        repeat (2) @(negedge clk);
        rd_chk(A_ST, 32'h400, "R2");
        chk("R6", 32'(irq), 0, "masked done keeps irq low");
        // R5 unmask, R6 irq rises
        tag = "R5";
        wr_reg(A_EN, 32'h400);
        rd_chk(A_MK, 32'hBFF, "R5");
        chk("R6", 32'(irq), 1, "unmasked done raises irq");
        // R3 selective clear
        tag = "R3";
        pulse(12'h204);
        wr_reg(A_ST, 32'h600);
        rd_chk(A_ST, 32'h004, "R3");
        chk("R6", 32'(irq), 0, "irq drops once unmasked bit cleared");
        // R4 set beats clear in the same cycle
        tag = "R4";
        ev = 12'h008; wr = 1'b1; addr = A_ST; wd = 32'h008;
        @(negedge clk);
        ev = '0; wr = 1'b0; wd = '0;
        rd_chk(A_ST, 32'h00C, "R4");
        wr_reg(A_ST, 32'hFFF);
        rd_chk(A_ST, 32'h000, "R3");
        // R5 / R6 full unmask then full silence
        tag = "R6";
        wr_reg(A_EN, 32'hFFF);
        rd_chk(A_MK, 32'h000, "R5");
        pulse(12'h040);
        @(negedge clk);
        chk("R6", 32'(irq), 1, "descriptor error raises irq one edge later");
        wr_reg(A_DS, 32'hFFF);
        @(negedge clk);
        chk("R6", 32'(irq), 0, "silencing all sources drops irq");
        rd_chk(A_MK, 32'hFFF, "R5");
        wr_reg(A_ST, 32'hFFF);
        // R7 counting and clear-on-read
        tag = "R7";
        bump(0, 3);
        bump(1, 5);
        rd_chk(A_SA, 3, "R7");
        rd_chk(A_SA, 0, "R7");
        rd = 1'b1; addr = A_DA; dinc = 1'b1;
        @(negedge clk);
        rd = 1'b0; dinc = 1'b0;
        chk("R7", rdata, 5, "read with coincident increment");
        rd_chk(A_DA, 1, "R7");
        rd_chk(A_ST, 32'h000, "R7");
        // R8 saturation and accounting error bits
        tag = "R8";
        bump(0, 260);
        rd_chk(A_SA, 255, "R8");
        rd_chk(A_ST, 32'h010, "R8");
        bump(1, 256);
        rd_chk(A_DA, 255, "R8");
        rd_chk(A_ST, 32'h030, "R8");
        wr_reg(A_ST, 32'hFFF);
        // R9 invalid accesses
        tag = "R9";
        rd_chk(12'h000, 0, "R10");
        rd_chk(A_ST, 32'h001, "R9");
        wr_reg(A_ST, 32'hFFF);
        wr_reg(A_MK, 32'h000);
        rd_chk(A_MK, 32'hFFF, "R9");
        rd_chk(A_ST, 32'h001, "R9");
        wr_reg(A_ST, 32'h001);
        rd_chk(A_ST, 32'h000, "R9");
        // R10 registered, held read data
        tag = "R10";
        rd = 1'b1; addr = A_MK;
        #1;
        chk("R10", rdata, 0, "read data before edge");
        @(negedge clk);
        rd = 1'b0;
        chk("R10", rdata, 32'hFFF, "read data after edge");
        addr = A_ST;
        repeat (2) @(negedge clk);
        chk("R10", rdata, 32'hFFF, "read data held without strobe");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule